// File: doc/BRIEF.md
# TLB Refill Victim Selector

This block picks the translation-table slot that a refill will overwrite. A refill request carries its page size, its virtual address, and is taken together with the currently configured page size of the set-associative section and the current address-space identifier. When the request's page size equals that configured size, the candidates are the ways of one set of the set-associative section. Otherwise the candidates are the entries of the small fully associative section placed after it.

The selector reads one candidate per clock through a read port (`cand_en`, `cand_idx`), to which the table answers in the same cycle with the entry's valid flag and owner identifier. It walks the candidates in ascending order. An unoccupied slot ends the walk at once. If every slot is occupied, it takes the last slot owned by another address space, and only when all slots belong to the current address space does it fall back to a pseudo-random slot drawn from a free-running LFSR. The result appears as a one-cycle pulse with the chosen index. Writing the entry and flushing any cached translations are left to the caller.

Requests use a valid/ready handshake: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the selector is idle, so a request offered while a walk or its result pulse is in progress is ignored and must be held or re-offered. The result has no back-pressure: the caller must take `res_index` in the single cycle `res_valid` is high. `WAYS` and `ASSOC_N` must be powers of two, at least 2 and at most 65536.

Top module: `refill_victim_sel`

## Requirements
- R1: After reset, `req_ready` is 1, and `res_valid` and `cand_en` are 0.
- R2: A request whose page size equals the configured set-associative page size walks the `WAYS` ways of one set. Any other request walks the `ASSOC_N` associative entries, whose indices run from `WAYS*256` to `WAYS*256+ASSOC_N-1`.
- R3: In set-associative mode the set number is `(vaddr >> (cfg_page_size+1)) & 0xFF`, and the index of way w is `w*256 + set`.
- R4: Candidate k (from 0) is presented on `cand_idx` with `cand_en` high in the k-th cycle after the accepting edge, one candidate per clock and in ascending order.
- R5: The first candidate whose valid flag is 0 is chosen. The walk stops there, and `res_valid` pulses in the next cycle with that index.
- R6: When every candidate is valid, the choice is the highest-numbered candidate whose owner identifier differs from the current identifier, and the result follows the last candidate by one cycle.
- R7: When every candidate is valid and owned by the current identifier, the result is some candidate of the same range (same set in set-associative mode), chosen from an LFSR.
- R8: While a walk or its result pulse is in progress, `req_ready` is 0 and `req_valid` has no effect.
- R9: `res_valid` is high for exactly one cycle, and `req_ready` returns to 1 in the following cycle.
- R10: Page sizes, address and identifier are captured at the accepting edge. Changes on those inputs during the walk do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refill request offered |
| req_ready | output | 1 | Selector idle, request will be taken |
| req_pg_size | input | PS_W | Page size of the refill |
| cfg_set_pg_size | input | PS_W | Configured page size of the set-associative section |
| cur_asid | input | ASID_W | Current address-space identifier |
| req_vaddr | input | VA_W | Virtual address of the refill |
| cand_en | output | 1 | A candidate is being read this cycle |
| cand_idx | output | IDX_W | Table index of the candidate being read |
| cand_present | input | 1 | Valid flag of the entry at `cand_idx` (same cycle) |
| cand_asid | input | ASID_W | Owner identifier of the entry at `cand_idx` (same cycle) |
| res_valid | output | 1 | One-cycle pulse: the choice is ready |
| res_index | output | IDX_W | Chosen table index |

## Verification
Each result has a fixed due cycle counted from the accepting edge. Candidate k is on the read port in the k-th cycle after it, the result pulse comes one cycle after the last candidate read (candidate j if it was empty, otherwise the final one), and `req_ready` is back one cycle after that. The bench drives and samples on falling clock edges and, from the table contents it loaded, works out in advance which cycle ends the walk. It then checks the read index, the idle and pulse flags and the chosen index at exactly those falling edges. Requests offered during a walk and changes to the captured inputs are placed between those sample points, so that their lack of effect shows up in the same checks.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [1:0] {
    RVS_IDLE = 2'd0,
    RVS_WALK = 2'd1,
    RVS_DONE = 2'd2
  } rvs_state_e;

endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr #(
  parameter int          OUT_W = 3,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [15:0] q;
  logic        fb;

  // taps for a maximal-length 16-bit sequence
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[14:0], fb};
  end

  assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/rvs_index_gen.sv
module rvs_index_gen #(
  parameter int IDX_W      = 12,
  parameter int CNT_W      = 6,
  parameter int SET_W      = 8,
  parameter int SA_ENTRIES = 2048
) (
  input  logic             set_mode,
  input  logic [SET_W-1:0] set_idx,
  input  logic [CNT_W-1:0] slot,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slot_ext;
  logic [IDX_W-1:0] set_ext;

  assign slot_ext = IDX_W'(slot);
  assign set_ext  = IDX_W'(set_idx);

  // way-major layout in the set section, then the associative entries
  always_comb begin
    if (set_mode) idx = (slot_ext << SET_W) | set_ext;
    else          idx = slot_ext + IDX_W'(SA_ENTRIES);
  end
endmodule

// File: rtl/rvs_walk.sv
module rvs_walk
  import rvs_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cand_present,
  input  logic             cand_foreign,
  input  logic [CNT_W-1:0] last_slot,
  input  logic [IDX_W-1:0] cand_idx,
  input  logic [IDX_W-1:0] rnd_idx,
  output logic [CNT_W-1:0] slot,
  output logic             idle,
  output logic             walking,
  output logic             done,
  output logic [IDX_W-1:0] result
);
  rvs_state_e       state;
  logic             have_foreign;
  logic [IDX_W-1:0] foreign_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= RVS_IDLE;
      slot         <= '0;
      have_foreign <= 1'b0;
      foreign_idx  <= '0;
      result       <= '0;
    end else begin
      unique case (state)
        RVS_IDLE: begin
          if (start) begin
            state        <= RVS_WALK;
            slot         <= '0;
            have_foreign <= 1'b0;
          end
        end
        RVS_WALK: begin
          if (!cand_present) begin
            result <= cand_idx;
            state  <= RVS_DONE;
          end else begin
            if (cand_foreign) begin
              foreign_idx  <= cand_idx;
              have_foreign <= 1'b1;
            end
            if (slot == last_slot) begin
              if (cand_foreign)      result <= cand_idx;
              else if (have_foreign) result <= foreign_idx;
              else                   result <= rnd_idx;
              state <= RVS_DONE;
            end else begin
              slot <= slot + CNT_W'(1);
            end
          end
        end
        RVS_DONE: state <= RVS_IDLE;
        default:  state <= RVS_IDLE;
      endcase
    end
  end

  assign idle    = (state == RVS_IDLE);
  assign walking = (state == RVS_WALK);
  assign done    = (state == RVS_DONE);
endmodule

// File: rtl/refill_victim_sel.sv
module refill_victim_sel #(
  parameter int          VA_W      = 48,
  parameter int          PS_W      = 6,
  parameter int          ASID_W    = 10,
  parameter int          SET_W     = 8,
  parameter int          WAYS      = 8,
  parameter int          ASSOC_N   = 64,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int SETS       = 1 << SET_W,
  localparam int SA_ENTRIES = WAYS * SETS,
  localparam int TOTAL      = SA_ENTRIES + ASSOC_N,
  localparam int IDX_W      = $clog2(TOTAL),
  localparam int MAXC       = (WAYS > ASSOC_N) ? WAYS : ASSOC_N,
  localparam int CNT_W      = $clog2(MAXC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PS_W-1:0]   req_pg_size,
  input  logic [PS_W-1:0]   cfg_set_pg_size,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              cand_en,
  output logic [IDX_W-1:0]  cand_idx,
  input  logic              cand_present,
  input  logic [ASID_W-1:0] cand_asid,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_index
);
  logic              accept;
  logic [PS_W:0]     shamt;
  logic [SET_W-1:0]  set_d;
  logic              mode_q;
  logic [SET_W-1:0]  set_q;
  logic [ASID_W-1:0] asid_q;
  logic              foreign;
  logic [CNT_W-1:0]  last_slot;
  logic [CNT_W-1:0]  rnd_raw;
  logic [CNT_W-1:0]  rnd_slot;
  logic [CNT_W-1:0]  slot;
  logic [IDX_W-1:0]  rnd_idx;

  assign accept = req_valid && req_ready;
  assign shamt  = {1'b0, cfg_set_pg_size} + (PS_W+1)'(1);
  assign set_d  = SET_W'(req_vaddr >> shamt);

  // request fields are captured once, at the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      set_q  <= '0;
      asid_q <= '0;
    end else if (accept) begin
      mode_q <= (req_pg_size == cfg_set_pg_size);
      set_q  <= set_d;
      asid_q <= cur_asid;
    end
  end

  assign foreign   = (cand_asid != asid_q);
  assign last_slot = mode_q ? CNT_W'(WAYS - 1) : CNT_W'(ASSOC_N - 1);
  assign rnd_slot  = rnd_raw & last_slot;

  rvs_lfsr #(.OUT_W(CNT_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk (clk),
    .rst_n (rst_n),
    .rnd (rnd_raw)
  );

  rvs_index_gen #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .SET_W(SET_W), .SA_ENTRIES(SA_ENTRIES)
  ) u_cand_map (
    .set_mode (mode_q),
    .set_idx  (set_q),
    .slot     (slot),
    .idx      (cand_idx)
  );

  rvs_index_gen #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .SET_W(SET_W), .SA_ENTRIES(SA_ENTRIES)
  ) u_rnd_map (
    .set_mode (mode_q),
    .set_idx  (set_q),
    .slot     (rnd_slot),
    .idx      (rnd_idx)
  );

  rvs_walk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .cand_present (cand_present),
    .cand_foreign (foreign),
    .last_slot    (last_slot),
    .cand_idx     (cand_idx),
    .rnd_idx      (rnd_idx),
    .slot         (slot),
    .idle         (req_ready),
    .walking      (cand_en),
    .done         (res_valid),
    .result       (res_index)
  );
endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
  parameter int IDX_W = 12,
  parameter int SETS  = 256,
  parameter int TOTAL = 2112
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             cand_en,
  input logic [IDX_W-1:0] cand_idx,
  input logic             cand_present,
  input logic             res_valid,
  input logic [IDX_W-1:0] res_index
);
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_en |-> !req_ready);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_ready_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> req_ready);

  assert_empty_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_en && !cand_present) |=> (res_valid && res_index == $past(cand_idx)));

  assert_ascending_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_en && $past(cand_en)) |->
      ((cand_idx == $past(cand_idx) + IDX_W'(1)) ||
       (cand_idx == $past(cand_idx) + IDX_W'(SETS))));

  assert_result_in_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_index) < TOTAL));
endmodule

bind refill_victim_sel rvs_checker #(
  .IDX_W(IDX_W), .SETS(SETS), .TOTAL(TOTAL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .cand_en      (cand_en),
  .cand_idx     (cand_idx),
  .cand_present (cand_present),
  .res_valid    (res_valid),
  .res_index    (res_index)
);

// File: tb/refill_victim_sel_bench.sv
`timescale 1ns/1ps
module refill_victim_sel_bench;
  localparam int ASSOC_N = 16;
  localparam int TOTAL   = 8 * 256 + ASSOC_N;
  localparam int IDX_W   = $clog2(TOTAL);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [5:0]        req_pg_size = '0;
  logic [5:0]        cfg_set_pg_size = '0;
  logic [9:0]        cur_asid = '0;
  logic [47:0]       req_vaddr = '0;
  logic              cand_en;
  logic [IDX_W-1:0]  cand_idx;
  logic              cand_present;
  logic [9:0]        cand_asid;
  logic              res_valid;
  logic [IDX_W-1:0]  res_index;

  logic       tab_e    [0:TOTAL-1];
  logic [9:0] tab_asid [0:TOTAL-1];

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  assign cand_present = tab_e[cand_idx];
  assign cand_asid    = tab_asid[cand_idx];

  refill_victim_sel #(.ASSOC_N(ASSOC_N)) u_refill_victim_sel (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_pg_size (req_pg_size), .cfg_set_pg_size (cfg_set_pg_size),
    .cur_asid (cur_asid), .req_vaddr (req_vaddr),
    .cand_en (cand_en), .cand_idx (cand_idx),
    .cand_present (cand_present), .cand_asid (cand_asid),
    .res_valid (res_valid), .res_index (res_index)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int slot_idx(input bit sm, input int setv, input int k);
    return sm ? (k * 256 + setv) : (2048 + k);
  endfunction

  task automatic run_one(input bit sm, input logic [47:0] va, input logic [5:0] sps,
                         input logic [9:0] asid, input bit poke);
    int setv;
    int n;
    int j;
    bit found_e;
    int lastf;
    int expv;
    setv = int'((va >> (int'(sps) + 1)) & 48'hFF);
    n = sm ? 8 : ASSOC_N;
    j = n - 1;
    found_e = 1'b0;
    lastf = -1;
    for (int k = 0; k < n; k++) begin
      if (!found_e) begin
        if (!tab_e[slot_idx(sm, setv, k)]) begin
          found_e = 1'b1;
          j = k;
        end else if (tab_asid[slot_idx(sm, setv, k)] != asid) begin
          lastf = slot_idx(sm, setv, k);
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_pg_size = sm ? sps : sps + 6'd1;
    cfg_set_pg_size = sps;
    req_vaddr = va;
    cur_asid = asid;
    chk(req_ready == 1'b1, "R9 idle before request", longint'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = poke;
    if (poke) begin // R10: disturb captured inputs during the walk
      req_vaddr = ~va;
      cur_asid = ~asid;
      cfg_set_pg_size = sps + 6'd3;
      req_pg_size = sm ? sps + 6'd5 : sps + 6'd3;
    end
    for (int m = 0; m <= j + 2; m++) begin
      if (m > 0) @(negedge clk);
      if (m == 2) req_valid = 1'b0;
      if (m <= j) begin
        chk(cand_en && int'(cand_idx) == slot_idx(sm, setv, m),
            sm ? "R3 R4 set walk index" : "R2 R4 assoc walk index",
            longint'(cand_idx), slot_idx(sm, setv, m));
        chk(!res_valid, "R5 no early result", longint'(res_valid), 0);
        chk(!req_ready, "R8 busy during walk", longint'(req_ready), 0);
      end else if (m == j + 1) begin
        chk(res_valid, "R5 R6 result timing", longint'(res_valid), 1);
        if (found_e) begin
          expv = slot_idx(sm, setv, j);
          chk(int'(res_index) == expv, "R5 first empty", longint'(res_index), expv);
        end else if (lastf >= 0) begin
          chk(int'(res_index) == lastf, "R6 last foreign", longint'(res_index), lastf);
        end else if (sm) begin
          chk((int'(res_index) % 256) == setv && int'(res_index) < 2048,
              "R7 random in set", longint'(res_index), setv);
        end else begin
          chk(int'(res_index) >= 2048 && int'(res_index) < TOTAL,
              "R7 random in assoc range", longint'(res_index), 2048);
        end
      end else begin
        chk(!res_valid && req_ready && !cand_en, "R9 pulse ends, idle again",
            longint'({res_valid, req_ready, cand_en}), 3'b010);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) begin
      tab_e[i] = 1'b1;
      tab_asid[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !cand_en, "R1 reset state",
        longint'({req_ready, res_valid, cand_en}), 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid && !cand_en, "R1 state after reset",
        longint'({req_ready, res_valid, cand_en}), 3'b100);

    // set section: every mix of empty / foreign / own over the 8 ways
    for (int p = 0; p < 6561; p++) begin
      logic [5:0]  sps;
      logic [9:0]  asid;
      logic [47:0] va;
      int setv;
      int d;
      case (p % 4)
        0: sps = 6'd12;
        1: sps = 6'd13;
        2: sps = 6'd14;
        default: sps = 6'd6;
      endcase
      setv = p % 256;
      asid = 10'(p * 37);
      va = ((48'(p) * 48'd40503) << (int'(sps) + 9)) |
           (48'(setv) << (int'(sps) + 1)) |
           (48'(p * 13) & ((48'd1 << (int'(sps) + 1)) - 48'd1));
      d = p;
      for (int w = 0; w < 8; w++) begin
        tab_e[w * 256 + setv] = (d % 3) != 0;
        tab_asid[w * 256 + setv] = ((d % 3) == 1) ? (asid ^ 10'h155) : asid;
        d = d / 3;
      end
      run_one(1'b1, va, sps, asid, (p % 53) == 0);
    end

    // set section, all own: several random picks
    for (int r = 0; r < 8; r++) begin
      for (int w = 0; w < 8; w++) begin
        tab_e[w * 256 + 77] = 1'b1;
        tab_asid[w * 256 + 77] = 10'h2A;
      end
      run_one(1'b1, 48'd77 << 13, 6'd12, 10'h2A, r[0]);
    end

    // associative section: first empty at each position
    for (int p = 0; p < ASSOC_N; p++) begin
      for (int k = 0; k < ASSOC_N; k++) begin
        tab_e[2048 + k] = (k != p);
        tab_asid[2048 + k] = (k < p && k[0]) ? 10'h301 : 10'h0C3;
      end
      run_one(1'b0, 48'h1234_5678_9ABC + 48'(p), 6'd13, 10'h0C3, p == 5);
    end

    // associative section: foreign owners at positions a and b
    for (int a = 0; a < ASSOC_N; a++) begin
      for (int b = a; b < ASSOC_N; b++) begin
        for (int k = 0; k < ASSOC_N; k++) begin
          tab_e[2048 + k] = 1'b1;
          tab_asid[2048 + k] = (k == a || k == b) ? 10'h011 : 10'h3F0;
        end
        run_one(1'b0, 48'(a * 4096 + b), 6'd12, 10'h3F0, (a + b) % 29 == 0);
      end
    end

    // associative section, all own: random picks
    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < ASSOC_N; k++) begin
        tab_e[2048 + k] = 1'b1;
        tab_asid[2048 + k] = 10'h155;
      end
      run_one(1'b0, 48'(r), 6'd20, 10'h155, r == 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule